// File: doc/BRIEF.md
# Montgomery-Ladder Point-Multiplication Sequencer

This block is the control side of a binary-field elliptic-curve point multiplier that works in Lopez-Dahab projective coordinates. It does no arithmetic itself. Each cycle it tells a register file and a one-cycle arithmetic unit which two operands to read, where to write the result and which result to write back (sum, product, square or a plain pass of operand A). A run goes through four phases in a fixed order. First it waits until the scalar and the curve parameters have been loaded. Then it converts the base point to projective form. Then it runs one ladder step per scalar bit. Last, it converts the result back to affine form.

The scalar is scanned from the bit just below its most significant bit down to bit 0. The controller publishes the index of the bit it wants (`keyBitIdx`), and the key register returns that bit on `keyBit`. The bit decides which of the two projective points is the addition target and which is doubled. Each ladder step is a 14-instruction sequence held in a small ROM. The conversion back to affine form uses two fixed-length inversion windows followed by a short tail of multiply and add operations.

Register-file addresses are X1=0, Z1=1, X2=2, Z2=3, T1=4, T2=5. When an operand select is 1, the matching read address instead indexes the parameter source: x of P=0, y of P=1, curve constant b=2, constant one=3. The write-back codes are: sum=0, product=1, square=2, pass operand A=3.

Top module: `pmLadderCtrl`

## Requirements
- R1: After reset, `phase` is 0 (load), `done` is 0 and `wrEn` is 0.
- R2: A `start` pulse is ignored, leaving `phase` at 0, unless at least `ceil(KEY_BITS/8)` key-byte strobes and at least `3*ceil(KEY_BITS/8)` parameter-byte strobes have been seen since reset or since the last accepted start.
- R3: The cycle after an accepted start, `phase` becomes 1 (initialize) and stays there for exactly 5 cycles. Its first instruction is a square of parameter x of P written to Z2: `opSelA`=1, `rdAddrA`=0, `wrAddr`=3, `wbSel`=2.
- R4: Phase 2 (ladder) follows and lasts exactly 14*(KEY_BITS-1) cycles. During iteration i (counting from 0), `keyBitIdx` equals KEY_BITS-2-i and holds steady for all 14 cycles.
- R5: In step 0 of each iteration, `rdAddrA` and `wrAddr` are 0 (X1) when the inspected bit is 1 and 2 (X2) when it is 0. In step 7, the doubling writes `wrAddr` 2 (X2) when the bit is 1 and 0 (X1) when it is 0.
- R6: Phase 3 (output) follows and lasts 2*INV_CYCLES+TAIL_CYCLES cycles, 1194 by default. Its first cycle reads Z1 (`rdAddrA`=1) to start the first inversion. Cycle INV_CYCLES reads Z2 (`rdAddrA`=3) to start the second.
- R7: At the end of phase 3, `phase` returns to 0 and `done` rises. `done` then stays high, including through reloading, until the cycle after the next accepted start, where it is 0.
- R8: Key-byte and parameter-byte strobes that arrive while phase is 1, 2 or 3 are not counted. Without a fresh load, a start after such a run is ignored.
- R9: `wrEn` is 1 in every cycle of phases 1, 2 and 3, and 0 in phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a point multiplication |
| keyByteStb | input | 1 | One scalar byte was written to the key register |
| parByteStb | input | 1 | One curve-parameter byte was written to the parameter buffers |
| keyBit | input | 1 | Scalar bit selected by `keyBitIdx` |
| keyBitIdx | output | $clog2(KEY_BITS) | Index of the scalar bit being inspected |
| phase | output | 2 | Current phase: 0 load, 1 initialize, 2 ladder, 3 output |
| rdAddrA | output | 3 | First operand address |
| rdAddrB | output | 3 | Second operand address |
| wrAddr | output | 3 | Result destination address in the register file |
| wrEn | output | 1 | Write the result this cycle |
| opSelA | output | 1 | First operand from parameter source (1) or register file (0) |
| opSelB | output | 1 | Second operand from parameter source (1) or register file (0) |
| wbSel | output | 2 | Result to write back: 0 sum, 1 product, 2 square, 3 pass A |
| done | output | 1 | Result available; held until the next accepted start |

## Verification
The bench uses an 8-bit scalar with short inversion windows. It sweeps all 256 scalars, so both branch orderings appear at every bit position, including the all-zero and all-one keys that never switch branch. For every scalar it counts the cycles spent in each phase and checks the bit index of each ladder iteration. Those two checks separate a wrong scan order or an off-by-one loop bound from a wrong branch choice. Separate starts are issued with no load, with a key-only load, and after a run during which the byte strobes were held high. These show whether start gating depends on a complete, fresh load.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int INIT_STEPS   = 5;
  localparam int LADDER_STEPS = 14;

  typedef enum logic [1:0] {
    PH_LOAD = 2'd0, PH_INIT = 2'd1, PH_LADDER = 2'd2, PH_OUTPUT = 2'd3
  } phase_e;

  typedef enum logic [1:0] {SEG_INV1 = 2'd0, SEG_INV2 = 2'd1, SEG_TAIL = 2'd2} seg_e;

  typedef enum logic [1:0] {WB_ADD = 2'd0, WB_MUL = 2'd1, WB_SQR = 2'd2, WB_PASS = 2'd3} wb_e;

  // Operand roles: fixed registers, ladder roles swapped by the key bit,
  // temporaries, and parameter-source entries.
  typedef enum logic [3:0] {
    R_NONE, R_X1, R_Z1, R_X2, R_Z2, R_XA, R_ZA, R_XD, R_ZD,
    R_T1, R_T2, R_PX, R_PY, R_PB, R_ONE
  } role_e;

  typedef struct packed {
    phase_e     phase;
    logic [3:0] instrIdx;
    seg_e       outSeg;
    logic       segFirst;
    logic       tailOdd;
  } seqStrobe_t;

  typedef struct packed {
    role_e srcA;
    role_e srcB;
    role_e dst;
    wb_e   wb;
  } instr_t;
endpackage

// File: rtl/pmcSequencer.sv
module pmcSequencer
  import pmc_pkg::*;
#(
  parameter int KEY_BITS    = 571,
  parameter int INV_CYCLES  = 583,
  parameter int TAIL_CYCLES = 28,
  localparam int IDX_W      = $clog2(KEY_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             keyByteStb,
  input  logic             parByteStb,
  output seqStrobe_t       strobe,
  output logic [IDX_W-1:0] keyBitIdx,
  output logic             done
);
  localparam int KEY_BYTES  = (KEY_BITS + 7) / 8;
  localparam int PAR_BYTES  = 3 * KEY_BYTES;
  localparam int OUT_CYCLES = 2 * INV_CYCLES + TAIL_CYCLES;
  localparam int CNT_W      = $clog2(OUT_CYCLES + 1);
  localparam int BYTE_W     = $clog2(PAR_BYTES + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  cnt;
  logic [3:0]        step;
  logic [IDX_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] keyCnt, parCnt;
  logic              loadedOk, startOk;

  assign loadedOk  = (keyCnt == BYTE_W'(KEY_BYTES)) && (parCnt == BYTE_W'(PAR_BYTES));
  assign startOk   = start && loadedOk;
  assign keyBitIdx = bitIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_LOAD;
      cnt    <= '0;
      step   <= '0;
      bitIdx <= '0;
      keyCnt <= '0;
      parCnt <= '0;
      done   <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD: begin
          if (startOk) begin
            phase  <= PH_INIT;
            cnt    <= '0;
            done   <= 1'b0;
            keyCnt <= '0;
            parCnt <= '0;
          end else begin
            if (keyByteStb && keyCnt != BYTE_W'(KEY_BYTES)) keyCnt <= keyCnt + BYTE_W'(1);
            if (parByteStb && parCnt != BYTE_W'(PAR_BYTES)) parCnt <= parCnt + BYTE_W'(1);
          end
        end
        PH_INIT: begin
          if (cnt == CNT_W'(INIT_STEPS - 1)) begin
            phase  <= PH_LADDER;
            cnt    <= '0;
            step   <= '0;
            bitIdx <= IDX_W'(KEY_BITS - 2);
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_LADDER: begin
          if (step == 4'(LADDER_STEPS - 1)) begin
            step <= '0;
            if (bitIdx == '0) begin
              phase <= PH_OUTPUT;
              cnt   <= '0;
            end else begin
              bitIdx <= bitIdx - IDX_W'(1);
            end
          end else begin
            step <= step + 4'd1;
          end
        end
        default: begin
          if (cnt == CNT_W'(OUT_CYCLES - 1)) begin
            phase <= PH_LOAD;
            cnt   <= '0;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strobe.phase    = phase;
    strobe.instrIdx = (phase == PH_INIT) ? 4'(cnt) : step;
    strobe.outSeg   = SEG_TAIL;
    strobe.segFirst = 1'b0;
    strobe.tailOdd  = cnt[0];
    if (cnt < CNT_W'(INV_CYCLES)) begin
      strobe.outSeg   = SEG_INV1;
      strobe.segFirst = (cnt == '0);
    end else if (cnt < CNT_W'(2 * INV_CYCLES)) begin
      strobe.outSeg   = SEG_INV2;
      strobe.segFirst = (cnt == CNT_W'(INV_CYCLES));
    end
  end

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && !loadedOk) |=> (phase == PH_LOAD));

  // R3
  init_len_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_INIT && cnt == CNT_W'(INIT_STEPS - 1)) |=> (phase == PH_LADDER && step == 4'd0));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LADDER && step != 4'd0) |-> $stable(bitIdx));

  // R6
  out_end_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OUTPUT && cnt == CNT_W'(OUT_CYCLES - 1)) |=> (phase == PH_LOAD && done));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !startOk) |=> done);
endmodule

// File: rtl/pmcInstrGen.sv
module pmcInstrGen
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seqStrobe_t strobe,
  input  logic       keyBit,
  output logic [2:0] rdAddrA,
  output logic [2:0] rdAddrB,
  output logic [2:0] wrAddr,
  output logic       wrEn,
  output logic       opSelA,
  output logic       opSelB,
  output logic [1:0] wbSel
);
  function automatic logic [2:0] roleAddr(input role_e r, input logic kb);
    case (r)
      R_X1, R_PX:  return 3'd0;
      R_Z1, R_PY:  return 3'd1;
      R_X2, R_PB:  return 3'd2;
      R_Z2, R_ONE: return 3'd3;
      R_XA:        return kb ? 3'd0 : 3'd2;
      R_ZA:        return kb ? 3'd1 : 3'd3;
      R_XD:        return kb ? 3'd2 : 3'd0;
      R_ZD:        return kb ? 3'd3 : 3'd1;
      R_T1:        return 3'd4;
      R_T2:        return 3'd5;
      default:     return 3'd0;
    endcase
  endfunction

  function automatic logic isParam(input role_e r);
    return (r == R_PX) || (r == R_PY) || (r == R_PB) || (r == R_ONE);
  endfunction

  // Affine to projective conversion.
  function automatic instr_t initRom(input logic [3:0] idx);
    case (idx)
      4'd0:    return '{srcA: R_PX, srcB: R_NONE, dst: R_Z2, wb: WB_SQR};
      4'd1:    return '{srcA: R_PX, srcB: R_NONE, dst: R_X1, wb: WB_PASS};
      4'd2:    return '{srcA: R_ONE, srcB: R_NONE, dst: R_Z1, wb: WB_PASS};
      4'd3:    return '{srcA: R_Z2, srcB: R_NONE, dst: R_X2, wb: WB_SQR};
      default: return '{srcA: R_X2, srcB: R_PB, dst: R_X2, wb: WB_ADD};
    endcase
  endfunction

  // One ladder step: add into (XA,ZA), double (XD,ZD).
  function automatic instr_t ladderRom(input logic [3:0] idx);
    case (idx)
      4'd0:    return '{srcA: R_XA, srcB: R_ZD, dst: R_XA, wb: WB_MUL};
      4'd1:    return '{srcA: R_ZA, srcB: R_XD, dst: R_ZA, wb: WB_MUL};
      4'd2:    return '{srcA: R_XA, srcB: R_ZA, dst: R_T1, wb: WB_MUL};
      4'd3:    return '{srcA: R_XA, srcB: R_ZA, dst: R_ZA, wb: WB_ADD};
      4'd4:    return '{srcA: R_ZA, srcB: R_NONE, dst: R_ZA, wb: WB_SQR};
      4'd5:    return '{srcA: R_PX, srcB: R_ZA, dst: R_XA, wb: WB_MUL};
      4'd6:    return '{srcA: R_XA, srcB: R_T1, dst: R_XA, wb: WB_ADD};
      4'd7:    return '{srcA: R_XD, srcB: R_NONE, dst: R_XD, wb: WB_SQR};
      4'd8:    return '{srcA: R_ZD, srcB: R_NONE, dst: R_ZD, wb: WB_SQR};
      4'd9:    return '{srcA: R_ZD, srcB: R_NONE, dst: R_T1, wb: WB_SQR};
      4'd10:   return '{srcA: R_PB, srcB: R_T1, dst: R_T1, wb: WB_MUL};
      4'd11:   return '{srcA: R_XD, srcB: R_ZD, dst: R_ZD, wb: WB_MUL};
      4'd12:   return '{srcA: R_XD, srcB: R_NONE, dst: R_XD, wb: WB_SQR};
      default: return '{srcA: R_XD, srcB: R_T1, dst: R_XD, wb: WB_ADD};
    endcase
  endfunction

  instr_t ins;

  always_comb begin
    ins = '{srcA: R_NONE, srcB: R_NONE, dst: R_NONE, wb: WB_ADD};
    case (strobe.phase)
      PH_INIT:   ins = initRom(strobe.instrIdx);
      PH_LADDER: ins = ladderRom(strobe.instrIdx);
      PH_OUTPUT: begin
        case (strobe.outSeg)
          SEG_INV1: ins = strobe.segFirst ? '{srcA: R_Z1, srcB: R_NONE, dst: R_T2, wb: WB_PASS}
                                          : '{srcA: R_T2, srcB: R_NONE, dst: R_T2, wb: WB_SQR};
          SEG_INV2: ins = strobe.segFirst ? '{srcA: R_Z2, srcB: R_NONE, dst: R_T1, wb: WB_PASS}
                                          : '{srcA: R_T1, srcB: R_NONE, dst: R_T1, wb: WB_SQR};
          default:  ins = strobe.tailOdd ? '{srcA: R_Z1, srcB: R_PY, dst: R_Z1, wb: WB_ADD}
                                         : '{srcA: R_X1, srcB: R_T2, dst: R_X1, wb: WB_MUL};
        endcase
      end
      default: ;
    endcase
  end

  assign rdAddrA = roleAddr(ins.srcA, keyBit);
  assign rdAddrB = roleAddr(ins.srcB, keyBit);
  assign wrAddr  = roleAddr(ins.dst, keyBit);
  assign opSelA  = isParam(ins.srcA);
  assign opSelB  = isParam(ins.srcB);
  assign wbSel   = ins.wb;
  assign wrEn    = (strobe.phase != PH_LOAD);

  // R5
  ladder_dest_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.phase == PH_LADDER && strobe.instrIdx == 4'd0) |-> (wrAddr == (keyBit ? 3'd0 : 3'd2)));
endmodule

// File: rtl/pmLadderCtrl.sv
module pmLadderCtrl
  import pmc_pkg::*;
#(
  parameter int KEY_BITS    = 571,
  parameter int INV_CYCLES  = 583,
  parameter int TAIL_CYCLES = 28,
  localparam int IDX_W      = $clog2(KEY_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             keyByteStb,
  input  logic             parByteStb,
  input  logic             keyBit,
  output logic [IDX_W-1:0] keyBitIdx,
  output logic [1:0]       phase,
  output logic [2:0]       rdAddrA,
  output logic [2:0]       rdAddrB,
  output logic [2:0]       wrAddr,
  output logic             wrEn,
  output logic             opSelA,
  output logic             opSelB,
  output logic [1:0]       wbSel,
  output logic             done
);
  seqStrobe_t strobe;

  pmcSequencer #(
    .KEY_BITS(KEY_BITS), .INV_CYCLES(INV_CYCLES), .TAIL_CYCLES(TAIL_CYCLES)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .keyByteStb(keyByteStb), .parByteStb(parByteStb),
    .strobe(strobe), .keyBitIdx(keyBitIdx), .done(done)
  );

  pmcInstrGen u_gen (
    .clk(clk), .rst(rst), .strobe(strobe), .keyBit(keyBit),
    .rdAddrA(rdAddrA), .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrEn(wrEn),
    .opSelA(opSelA), .opSelB(opSelB), .wbSel(wbSel)
  );

  assign phase = strobe.phase;
endmodule

// File: tb/pmLadderCtrl_bench.sv
module pmLadderCtrl_bench;
  localparam int KB   = 8;
  localparam int INV  = 6;
  localparam int TAIL = 4;
  localparam int IW   = $clog2(KB);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, start, keyByteStb, parByteStb, keyBit;
  logic [IW-1:0] keyBitIdx;
  logic [1:0] phase, wbSel;
  logic [2:0] rdAddrA, rdAddrB, wrAddr;
  logic wrEn, opSelA, opSelB, done;
  logic [KB-1:0] curKey;

  assign keyBit = curKey[keyBitIdx];

  pmLadderCtrl #(.KEY_BITS(KB), .INV_CYCLES(INV), .TAIL_CYCLES(TAIL)) u_pmLadderCtrl (
    .clk(clk), .rst(rst), .start(start), .keyByteStb(keyByteStb), .parByteStb(parByteStb),
    .keyBit(keyBit), .keyBitIdx(keyBitIdx), .phase(phase), .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB), .wrAddr(wrAddr), .wrEn(wrEn), .opSelA(opSelA), .opSelB(opSelB),
    .wbSel(wbSel), .done(done)
  );

  int nChk = 0;
  int nFail = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One key byte and three parameter bytes (KB=8).
  task automatic loadAll();
    keyByteStb = 1'b1; parByteStb = 1'b1;
    @(negedge clk);
    keyByteStb = 1'b0;
    repeat (2) @(negedge clk);
    parByteStb = 1'b0;
  endtask

  task automatic runOne(input logic [KB-1:0] k, input bit noisy);
    int nInit = 0, nLad = 0, nOut = 0, guard = 0;
    int badIdx = 0, badBr = 0, badWr = 0, outA0 = -1, outAInv = -1;
    bit initOk = 1'b0;
    curKey = k;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    keyByteStb = noisy; parByteStb = noisy;
    chk(done == 1'b0, "R7 done low after accepted start", int'(done), 0);
    while (!done && guard < 2000) begin
      guard++;
      if (wrEn !== 1'b1) badWr++;
      case (phase)
        2'd1: begin
          if (nInit == 0)
            initOk = (opSelA == 1'b1 && rdAddrA == 3'd0 && wrAddr == 3'd3 && wbSel == 2'd2);
          nInit++;
        end
        2'd2: begin
          int st, bi, expA, expD;
          st = nLad % 14;
          bi = KB - 2 - nLad / 14;
          expA = k[bi] ? 0 : 2;
          expD = k[bi] ? 2 : 0;
          if (int'(keyBitIdx) != bi) badIdx++;
          if (st == 0 && (int'(rdAddrA) != expA || int'(wrAddr) != expA)) badBr++;
          if (st == 7 && int'(wrAddr) != expD) badBr++;
          nLad++;
        end
        2'd3: begin
          if (nOut == 0) outA0 = int'(rdAddrA);
          if (nOut == INV) outAInv = int'(rdAddrA);
          nOut++;
        end
        default: badWr++;
      endcase
      @(negedge clk);
    end
    keyByteStb = 1'b0; parByteStb = 1'b0;
    chk(initOk, "R3 first init instruction squares xP into Z2", int'(initOk), 1);
    chk(nInit == 5, "R3 init phase length", nInit, 5);
    chk(nLad == 14 * (KB - 1), "R4 ladder phase length", nLad, 14 * (KB - 1));
    chk(badIdx == 0, "R4 scanned bit index per iteration", badIdx, 0);
    chk(badBr == 0, "R5 branch role swap by key bit", badBr, 0);
    chk(nOut == 2 * INV + TAIL, "R6 output phase length", nOut, 2 * INV + TAIL);
    chk(outA0 == 1, "R6 first inversion reads Z1", outA0, 1);
    chk(outAInv == 3, "R6 second inversion reads Z2", outAInv, 3);
    chk(badWr == 0, "R9 write enable through run", badWr, 0);
    chk(phase == 2'd0 && wrEn == 1'b0, "R9 idle after done", int'(phase), 0);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; keyByteStb = 1'b0; parByteStb = 1'b0; curKey = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(phase == 2'd0, "R1 reset phase", int'(phase), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);
    chk(wrEn == 1'b0, "R1 reset wrEn", int'(wrEn), 0);

    // R2: start with nothing loaded
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(phase == 2'd0, "R2 start before any load ignored", int'(phase), 0);

    // R2: start with only the key loaded
    keyByteStb = 1'b1; @(negedge clk); keyByteStb = 1'b0;
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(phase == 2'd0, "R2 start with key only ignored", int'(phase), 0);

    parByteStb = 1'b1; repeat (3) @(negedge clk); parByteStb = 1'b0;
    runOne(8'hB5, 1'b1);

    // R7 and R8: done holds; strobes seen during the run were not counted
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R7 done holds while idle", int'(done), 1);
    start = 1'b1; @(negedge clk); start = 1'b0; @(negedge clk);
    chk(phase == 2'd0, "R8 strobes during run not counted", int'(phase), 0);
    chk(done == 1'b1, "R7 done holds after ignored start", int'(done), 1);

    for (int k = 0; k < 256; k++) begin
      loadAll();
      chk(done == 1'b1, "R7 done holds through reload", int'(done), 1);
      runOne(k[KB-1:0], 1'b0);
    end

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual 150000 cycles expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule